// File: doc/BRIEF.md
# Sorted Group-By Stream Aggregator

This block reduces a stream of rows, each carrying a group key and a value, into one result per group. The rows must arrive already ordered by key. A group therefore ends exactly where the key changes from one row to the next. The block keeps only the running state of the group it is working on. It never holds a table of partial results, so its storage does not depend on how many groups pass through.

Each input beat is accepted over a valid/ready handshake and carries a last flag that marks the end of a stream. An opcode selects the reduction: sum, minimum, maximum, row count, or integer mean. The block reads the opcode on the first beat of a stream and keeps it until that stream ends. Each closed group leaves as a single (key, result) beat on a valid/ready output. If the output stalls, the block withholds input ready rather than lose a group.

Top module: `grp_agg_stream`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high. No output beat appears before an input row has been accepted.
- R2: When an accepted row's key differs from the key of the group in progress, that group closes. For every opcode except mean, its result is on the output in the cycle after the accepting clock edge.
- R3: A beat with in_last_i high closes the final group of the stream. A later stream starts a new group even when its first key equals the last key of the previous stream.
- R4: Opcode 0 (sum) produces the unsigned sum of the group's values modulo 2^W.
- R5: Opcode 1 produces the unsigned minimum and opcode 2 the unsigned maximum of the group's values.
- R6: Opcode 3 produces the number of rows in the group, zero-extended to W bits.
- R7: Opcode 4 produces the group's sum (modulo 2^W) divided by its row count, using unsigned integer division that truncates.
- R8: The opcode is taken from op_i on the first beat of a stream. Changes on op_i at any later beat of the same stream have no effect on that stream's results.
- R9: While out_valid_o is high and out_ready_i is low, the output key and result stay stable. Every group of every stream is delivered once, in order, no matter how long the output stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Reduction opcode, read on a stream's first beat |
| in_valid_i | input | 1 | Input row present |
| in_ready_o | output | 1 | Input row can be taken |
| in_key_i | input | W | Group key of the row |
| in_val_i | input | W | Value of the row |
| in_last_i | input | 1 | Row is the final one of its stream |
| out_valid_o | output | 1 | Result beat present |
| out_ready_i | input | 1 | Consumer takes the result beat |
| out_key_o | output | W | Key of the closed group |
| out_agg_o | output | W | Reduction result of the closed group |

## Verification
A group closed by a key change carries a non-mean result that is due in the cycle after the edge that accepted the new key. One directed case samples out_valid_o, out_key_o and out_agg_o at the next falling edge to pin that cycle. It then holds out_ready_i low for several cycles and checks that the beat stays stable and that input ready is withheld. The flush after a last beat takes one extra cycle, and mean results wait for the serial divider, which takes about W+2 cycles. For that reason every other result is matched in order against a bench-computed queue whenever a handshake completes, sampled just after the falling edge, so the exact cycle of those results does not affect the check. The drive and collect processes both act at the falling edge, and input ready does not depend on out_ready_i.

// File: rtl/grp_agg_pkg.sv
`timescale 1ns/1ps
package grp_agg_pkg;
  typedef enum logic [2:0] {
    AGG_SUM = 3'd0,
    AGG_MIN = 3'd1,
    AGG_MAX = 3'd2,
    AGG_CNT = 3'd3,
    AGG_AVG = 3'd4
  } agg_op_e;

  typedef enum logic [1:0] {
    FIN_IDLE = 2'd0,
    FIN_DIV  = 2'd1,
    FIN_OUT  = 2'd2
  } fin_state_e;
endpackage

// File: rtl/grp_agg_div.sv
`timescale 1ns/1ps
// Restoring divider, one quotient bit per cycle.
module grp_agg_div #(
  parameter int W  = 256,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          busy_o,
  output logic [W-1:0]  quot_o
);
  localparam int SW = $clog2(W + 1);

  logic [W-1:0]  quo_q;
  logic [DW-1:0] rem_q;
  logic [DW-1:0] dvs_q;
  logic [SW-1:0] step_q;
  logic [DW:0]   rem_sh;
  logic [DW:0]   rem_nx;
  logic          ge;

  always_comb begin
    rem_sh = {rem_q, quo_q[W-1]};
    ge     = rem_sh >= {1'b0, dvs_q};
    rem_nx = ge ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      step_q <= '0;
    end else if (start_i) begin
      quo_q  <= dividend_i;
      rem_q  <= '0;
      dvs_q  <= divisor_i;
      step_q <= SW'(W);
    end else if (step_q != '0) begin
      quo_q  <= {quo_q[W-2:0], ge};
      rem_q  <= rem_nx[DW-1:0];
      step_q <= step_q - 1'b1;
    end
  end

  assign busy_o = step_q != '0;
  assign quot_o = quo_q;

  assert_rem_fits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != '0) |-> !rem_nx[DW]);

  assert_rem_below_divisor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(busy_o)) |-> (rem_q < dvs_q));
endmodule

// File: rtl/grp_agg_fin.sv
`timescale 1ns/1ps
// Finishes a closed group and holds it as the single output beat.
module grp_agg_fin
  import grp_agg_pkg::*;
#(
  parameter int W  = 256,
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  agg_op_e       op_i,
  input  logic [W-1:0]  key_i,
  input  logic [W-1:0]  acc_i,
  input  logic [CW-1:0] cnt_i,
  output logic          idle_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [W-1:0]  out_key_o,
  output logic [W-1:0]  out_agg_o
);
  fin_state_e   st_q;
  logic [W-1:0] key_q;
  logic [W-1:0] agg_q;
  logic         div_start;
  logic         div_busy;
  logic [W-1:0] div_quot;

  assign div_start = req_i && (st_q == FIN_IDLE) && (op_i == AGG_AVG);

  grp_agg_div #(.W(W), .DW(CW)) div_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (acc_i),
    .divisor_i  (cnt_i),
    .busy_o     (div_busy),
    .quot_o     (div_quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= FIN_IDLE;
      key_q <= '0;
      agg_q <= '0;
    end else begin
      unique case (st_q)
        FIN_IDLE: if (req_i) begin
          key_q <= key_i;
          agg_q <= (op_i == AGG_CNT) ? W'(cnt_i) : acc_i;
          st_q  <= (op_i == AGG_AVG) ? FIN_DIV : FIN_OUT;
        end
        FIN_DIV: if (!div_busy) begin
          agg_q <= div_quot;
          st_q  <= FIN_OUT;
        end
        FIN_OUT: if (out_ready_i) st_q <= FIN_IDLE;
        default: st_q <= FIN_IDLE;
      endcase
    end
  end

  assign idle_o      = st_q == FIN_IDLE;
  assign out_valid_o = st_q == FIN_OUT;
  assign out_key_o   = key_q;
  assign out_agg_o   = agg_q;

  assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_key_o) && $stable(out_agg_o)));
endmodule

// File: rtl/grp_agg_stream.sv
`timescale 1ns/1ps
module grp_agg_stream
  import grp_agg_pkg::*;
#(
  parameter int W  = 256,
  parameter int CW = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   op_i,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_key_i,
  input  logic [W-1:0] in_val_i,
  input  logic         in_last_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_key_o,
  output logic [W-1:0] out_agg_o
);
  logic          have_q;
  logic          strm_q;
  logic          flush_q;
  agg_op_e       op_q;
  logic [W-1:0]  key_q;
  logic [W-1:0]  acc_q;
  logic [CW-1:0] cnt_q;
  logic          fin_idle;
  logic          key_eq;
  logic          fire;
  logic          close_req;
  logic          flush_req;

  function automatic logic [W-1:0] acc_step(agg_op_e op, logic [W-1:0] a, logic [W-1:0] v);
    case (op)
      AGG_MIN: return (v < a) ? v : a;
      AGG_MAX: return (v > a) ? v : a;
      AGG_CNT: return a;
      default: return a + v;
    endcase
  endfunction

  assign key_eq     = in_key_i == key_q;
  // Same-key rows may enter while the finisher is busy; a closing row may not.
  assign in_ready_o = !flush_q && (fin_idle || (have_q && key_eq));
  assign fire       = in_valid_i && in_ready_o;
  assign close_req  = fire && have_q && !key_eq;
  assign flush_req  = flush_q && fin_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q  <= 1'b0;
      strm_q  <= 1'b0;
      flush_q <= 1'b0;
      op_q    <= AGG_SUM;
      key_q   <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
    end else if (fire) begin
      if (!strm_q) op_q <= agg_op_e'(op_i);
      strm_q <= !in_last_i;
      if (have_q && key_eq) begin
        acc_q <= acc_step(op_q, acc_q, in_val_i);
        cnt_q <= cnt_q + 1'b1;
      end else begin
        have_q <= 1'b1;
        key_q  <= in_key_i;
        acc_q  <= in_val_i;
        cnt_q  <= CW'(1);
      end
      if (in_last_i) flush_q <= 1'b1;
    end else if (flush_req) begin
      flush_q <= 1'b0;
      have_q  <= 1'b0;
    end
  end

  grp_agg_fin #(.W(W), .CW(CW)) fin_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (close_req || flush_req),
    .op_i        (op_q),
    .key_i       (key_q),
    .acc_i       (acc_q),
    .cnt_i       (cnt_q),
    .idle_o      (fin_idle),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_key_o   (out_key_o),
    .out_agg_o   (out_agg_o)
  );

  assert_cnt_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_q |-> (cnt_q != '0));

  assert_op_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strm_q && $past(strm_q)) |-> $stable(op_q));

  assert_min_monotone_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fire && have_q && key_eq) && op_q == AGG_MIN) |-> (acc_q <= $past(acc_q)));

  assert_close_only_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_req |-> fin_idle);
endmodule

// File: tb/grp_agg_stream_tb.sv
`timescale 1ns/1ps
module grp_agg_stream_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 64;
  localparam int TC = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    op_i = '0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [TW-1:0] in_key_i = '0;
  logic [TW-1:0] in_val_i = '0;
  logic          in_last_i = 1'b0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic [TW-1:0] out_key_o;
  logic [TW-1:0] out_agg_o;

  int errors = 0;
  int checks = 0;
  logic [TW-1:0] rk [0:63];
  logic [TW-1:0] rv [0:63];
  logic [TW-1:0] ek [0:4095];
  logic [TW-1:0] ea [0:4095];
  int et [0:4095];
  int ewr = 0;
  int erd = 0;
  bit coll_en = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  grp_agg_stream #(.W(TW), .CW(TC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_key_i(in_key_i), .in_val_i(in_val_i), .in_last_i(in_last_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_key_o(out_key_o), .out_agg_o(out_agg_o)
  );

  task automatic chk(bit ok, string req, logic [TW-1:0] act, logic [TW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] exp_of(int op, logic [TW-1:0] s, logic [TW-1:0] mn,
                                           logic [TW-1:0] mx, int c);
    case (op)
      1: return mn;
      2: return mx;
      3: return TW'(c);
      4: return s / TW'(c);
      default: return s;
    endcase
  endfunction

  task automatic push_exp(logic [TW-1:0] k, logic [TW-1:0] a, int tag);
    ek[ewr] = k; ea[ewr] = a; et[ewr] = tag; ewr++;
  endtask

  // Reference model: split rows into runs of equal key.
  task automatic model_stream(int op, int n, int tag);
    logic [TW-1:0] s, mn, mx;
    int c;
    s = '0; mn = '0; mx = '0; c = 0;
    for (int i = 0; i < n; i++) begin
      if (i == 0 || rk[i] != rk[i-1]) begin
        if (i > 0) push_exp(rk[i-1], exp_of(op, s, mn, mx, c), tag);
        s = rv[i]; mn = rv[i]; mx = rv[i]; c = 1;
      end else begin
        s = s + rv[i];
        if (rv[i] < mn) mn = rv[i];
        if (rv[i] > mx) mx = rv[i];
        c++;
      end
    end
    push_exp(rk[n-1], exp_of(op, s, mn, mx, c), tag);
  endtask

  // R8: op_i is scrambled after the first beat of the stream.
  task automatic drive_stream(int op, int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      bit taken;
      taken = 0;
      while (!taken) begin
        @(negedge clk_i);
        if (gaps && ($urandom % 4 == 0)) begin
          in_valid_i = 1'b0;
        end else begin
          in_valid_i = 1'b1;
          in_key_i   = rk[i];
          in_val_i   = rv[i];
          in_last_i  = (i == n - 1);
          op_i       = (i == 0) ? 3'(op) : 3'($urandom % 8);
          #1;
          if (in_ready_o) begin
            @(posedge clk_i);
            taken = 1;
          end
        end
      end
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
  endtask

  task automatic run_stream(int op, int n, int tag);
    model_stream(op, n, tag);
    drive_stream(op, n, 1'b1);
  endtask

  task automatic drain();
    for (int t = 0; t < 30000 && erd != ewr; t++) @(negedge clk_i);
  endtask

  // Collector: in-order compare against the model queue.
  initial begin
    forever begin
      @(negedge clk_i);
      if (coll_en) out_ready_i = ($urandom % 3 != 0);
      #1;
      if (coll_en && out_valid_o && out_ready_i) begin
        if (erd >= ewr) begin
          chk(1'b0, "R9 unexpected row", out_key_o, '0);
        end else begin
          chk(out_key_o == ek[erd], $sformatf("R%0d key", et[erd]), out_key_o, ek[erd]);
          chk(out_agg_o == ea[erd], $sformatf("R%0d agg", et[erd]), out_agg_o, ea[erd]);
          erd++;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    #1;
    // R1: reset state, no spurious output
    chk(out_valid_o == 1'b0, "R1 out_valid", TW'(out_valid_o), 0);
    chk(in_ready_o == 1'b1, "R1 in_ready", TW'(in_ready_o), 1);

    // R2: close latency, R9: hold under stall
    rk[0] = 5; rv[0] = 3; rk[1] = 6; rv[1] = 4;
    push_exp(5, 3, 2); push_exp(6, 4, 2);
    drive_stream(0, 2, 1'b0);
    #1;
    chk(out_valid_o == 1'b1, "R2 valid next cycle", TW'(out_valid_o), 1);
    chk(out_key_o == 5, "R2 key", out_key_o, 5);
    chk(out_agg_o == 3, "R2 agg", out_agg_o, 3);
    repeat (3) @(negedge clk_i);
    #1;
    chk(out_valid_o == 1'b1 && out_key_o == 5, "R9 held key", out_key_o, 5);
    chk(out_agg_o == 3, "R9 held agg", out_agg_o, 3);
    chk(in_ready_o == 1'b0, "R9 input stalled", TW'(in_ready_o), 0);
    coll_en = 1;
    drain();

    // R4: sum wraps
    rk[0] = 1; rv[0] = '1; rk[1] = 1; rv[1] = 2;
    run_stream(0, 2, 4);
    // R5: min and max
    rk[0] = 2; rk[1] = 2; rk[2] = 2; rk[3] = 4;
    rv[0] = 9; rv[1] = 3; rv[2] = 7; rv[3] = 1;
    run_stream(1, 4, 5);
    run_stream(2, 4, 5);
    // R6: count
    rk[0] = 1; rk[1] = 1; rk[2] = 1; rk[3] = 3; rk[4] = 3;
    run_stream(3, 5, 6);
    // R7: truncating mean, including a wrapped sum
    rk[0] = 7; rv[0] = 7; rk[1] = 7; rv[1] = 8; rk[2] = 8; rv[2] = 5;
    rk[3] = 9; rv[3] = '1; rk[4] = 9; rv[4] = '1;
    run_stream(4, 5, 7);
    // R3: equal key across a stream boundary gives two groups
    rk[0] = 9; rv[0] = 4;
    run_stream(0, 1, 3);
    rv[0] = 5;
    run_stream(0, 1, 3);
    drain();

    // Random streams with mid-stream opcode noise (R8)
    for (int s = 0; s < 40; s++) begin
      int n;
      logic [TW-1:0] k;
      n = 1 + ($urandom % 40);
      k = TW'($urandom % 16);
      for (int i = 0; i < n; i++) begin
        if (i > 0 && ($urandom % 3 == 0)) k = k + TW'(1 + $urandom % 3);
        rk[i] = k;
        case ($urandom % 4)
          0: rv[i] = '1;
          1: rv[i] = TW'($urandom % 10);
          default: rv[i] = {$urandom, $urandom};
        endcase
      end
      run_stream(s % 5, n, 8);
    end
    drain();
    @(negedge clk_i);
    #1;
    chk(erd == ewr, "R9 all rows delivered", TW'(erd), TW'(ewr));
    chk(out_valid_o == 1'b0, "R9 no extra row", TW'(out_valid_o), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule